// File: doc/BRIEF.md
# Core module control register file

This block is the control and status register bank of a processor core module. A host reaches it over a simple register bus: a byte offset, a write strobe, a write word and a combinational read word. The register index is the byte offset divided by four. The bank holds an identification word, a fixed status word, two oscillator setting words and a 16-bit lock register. The oscillator words accept writes only while a 16-bit unlock key is held in the lock register.

A control register drives two board outputs. One lights a LED. The other selects whether boot flash or RAM answers at address zero. Writing a one to the control register's reset bit produces a single-cycle reset request pulse. Two flag words are updated through separate set and clear addresses, so a host can change single bits without a read-modify-write. A free-running reference counter, derived from the block clock by a prescaler, counts from reset. A read-only window above the register space serves memory-module presence bytes. The memory size code and one of those bytes are fixed at build time by a memory size parameter.

Top module: `cm_ctrl_regs`

## Requirements
- R1: Index 0 reads 0x411A3001, index 1 reads 0 and index 4 reads 0x00100000.
- R2: A write to index 5 keeps only write data bits 15:0. A read of index 5 returns 0x1A05F while the stored value is 0xA05F, and the stored value zero-extended otherwise. The reset value is 0.
- R3: The oscillator word (index 2, reset 0x01000048) and the auxiliary oscillator word (index 7, reset 0x0007FEFF) take a full 32-bit write only while index 5 holds 0xA05F. At any other time such a write leaves them unchanged.
- R4: The control register (index 3, reset 0) stores only write data bits 0 and 2, and reads them back in place, with bit 3 and every other bit reading 0. led_o follows bit 0 and remap_o follows bit 2, so remap_o=1 means RAM is at address zero.
- R5: A write to index 3 with data bit 3 set raises reset_req_o for exactly the one cycle after the write edge. A write with bit 3 clear never raises it.
- R6: Index 12 reads the flag word, and a write there ORs the data into it. A write to index 13 clears the bits set in the data. Indices 14 and 15 do the same for a second flag word, which index 14 reads. Indices 13 and 15 read 0, and both flag words reset to 0.
- R7: The SDRAM word (index 8) resets to 0x00011122 ORed with a size code: 0x10 for MEM_MB >= 256, 0x0C for >= 128, 0x08 for >= 64, 0x04 for >= 32, 0 below that. The init word (index 9) resets to 0x00000112. Both take full 32-bit writes.
- R8: Index 10 reads a 32-bit counter that is 0 at reset and advances by exactly 1 every REF_DIV clock cycles.
- R9: Byte offsets 0x100 to 0x17F read presence byte number offset[6:2], zero-extended. Byte 0 is 0x80, byte 2 is 0x04, and byte 31 is a density code: 64 for MEM_MB >= 256, 32 for >= 128, 16 for >= 64, 4 for >= 32, 2 otherwise. Offsets 0x180 to 0x1FF read 0, and writes anywhere in this window change nothing.
- R10: Every unmapped index (6, 11, 16 to 63) reads 0. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| remap_o | output | 1 | 1 selects RAM at address zero, 0 selects boot flash |
| led_o | output | 1 | LED drive from control bit 0 |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest behaviour to show at the ports is a write that is silently dropped. Any read only shows whether a value survived, so the bench must hold the lock in each of its states on purpose. It writes the oscillator words while locked, after loading the key through a write whose upper 16 bits are not zero, and again after relocking with a different key. Each time it reads back the earlier value. The reset pulse is checked for its width at the cycle after the write edge. The reference counter is checked for its exact cadence by sampling it twice, a known multiple of REF_DIV cycles apart.

// File: rtl/cm_regs_pkg.sv
// Package: shared constants and build-time helpers for the core module
// register bank. Assumes a 32-bit data path and word-indexed registers.
package cm_regs_pkg;

    localparam int IDX_IDENT    = 0;
    localparam int IDX_PROC     = 1;
    localparam int IDX_OSC      = 2;
    localparam int IDX_CTRL     = 3;
    localparam int IDX_STAT     = 4;
    localparam int IDX_LOCK     = 5;
    localparam int IDX_AUX      = 7;
    localparam int IDX_SDRAM    = 8;
    localparam int IDX_INIT     = 9;
    localparam int IDX_REFCNT   = 10;
    localparam int IDX_FLAG_SET = 12;
    localparam int IDX_FLAG_CLR = 13;
    localparam int IDX_NVF_SET  = 14;
    localparam int IDX_NVF_CLR  = 15;

    localparam logic [31:0] IDENT_WORD  = 32'h411A_3001;
    localparam logic [31:0] STAT_WORD   = 32'h0010_0000;
    localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
    localparam logic [31:0] OSC_RST     = 32'h0100_0048;
    localparam logic [31:0] AUX_RST     = 32'h0007_FEFF;
    localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;
    localparam logic [31:0] INIT_RST    = 32'h0000_0112;

    localparam int PRESENCE_LO = 'h100;
    localparam int PRESENCE_HI = 'h180;

    // Size code merged into the SDRAM word from the installed memory size.
    function automatic logic [31:0] sdram_size_code(input int mb);
        if (mb >= 256)     return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else               return 32'h00;
    endfunction

    // Density byte of the presence table for the installed memory size.
    function automatic logic [7:0] presence_density(input int mb);
        if (mb >= 256)     return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else               return 8'd2;
    endfunction

    // Presence byte k of the memory-module table; byte 31 is the density.
    function automatic logic [7:0] presence_byte(input logic [4:0] k,
                                                 input logic [7:0] density);
        case (k)
            5'd0:  return 8'd128;
            5'd1:  return 8'd8;
            5'd2:  return 8'd4;
            5'd3:  return 8'd11;
            5'd4:  return 8'd9;
            5'd5:  return 8'd1;
            5'd6:  return 8'd64;
            5'd8:  return 8'd2;
            5'd9:  return 8'hA0;
            5'd10: return 8'hA0;
            5'd13: return 8'd8;
            5'd15: return 8'd1;
            5'd16: return 8'h0E;
            5'd17: return 8'd4;
            5'd18: return 8'h1C;
            5'd19: return 8'd1;
            5'd20: return 8'd2;
            5'd21: return 8'h20;
            5'd22: return 8'hC0;
            5'd27: return 8'h30;
            5'd28: return 8'h28;
            5'd29: return 8'h30;
            5'd30: return 8'h28;
            5'd31: return density;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cm_key_lock.sv
// Module: key lock register and the two oscillator words it guards.
// Assumes write strobes are already decoded. A guarded word takes a write
// only while the lock holds the unlock key.
module cm_key_lock
    import cm_regs_pkg::*;
#(
    parameter int KEY_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_we,
    input  logic [1:0]        word_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [KEY_W-1:0]  lock_q,
    output logic              lock_open,
    output logic [DATA_W-1:0] osc_q,
    output logic [DATA_W-1:0] aux_q
);

    logic [DATA_W-1:0] word_q [2];

    // Purpose: hold the low half of the last lock write.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '0;
        else if (lock_we) lock_q <= wdata[KEY_W-1:0];
    end

    assign lock_open = (lock_q == UNLOCK_KEY);

    for (genvar g = 0; g < 2; g++) begin : g_guard
        localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? OSC_RST : AUX_RST;
        // Purpose: update one guarded word only while the key is present.
        always_ff @(posedge clk) begin
            if (!rst_n)                       word_q[g] <= RST_VAL;
            else if (word_we[g] && lock_open) word_q[g] <= wdata;
        end
    end

    assign osc_q = word_q[0];
    assign aux_q = word_q[1];

endmodule

// File: rtl/cm_setclr_bank.sv
// Module: one flag word updated through a set strobe and a clear strobe.
// Assumes the two strobes never fire together; if they do, set wins.
module cm_setclr_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags_q
);

    // Purpose: OR data into the word on set, remove data bits on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flags_q <= '0;
        else if (set_we) flags_q <= flags_q | wdata;
        else if (clr_we) flags_q <= flags_q & ~wdata;
    end

endmodule

// File: rtl/cm_ref_counter.sv
// Module: free-running reference counter behind a clock prescaler.
// Assumes DIV >= 1. The count advances once every DIV clock cycles from
// reset and wraps at its width.
module cm_ref_counter #(
    parameter int DIV   = 10,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_q
);

    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    // Purpose: divide the block clock down to the reference rate.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Purpose: count reference ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (tick) count_q <= count_q + 1'b1;
    end

endmodule

// File: rtl/cm_ctrl_unit.sv
// Module: control register bits and the reset request pulse.
// Assumes ctrl_we is a decoded write strobe. The reset bit is never stored.
module cm_ctrl_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic led_bit,
    input  logic remap_bit,
    input  logic reset_bit,
    output logic led_q,
    output logic remap_q,
    output logic reset_pulse
);

    // Purpose: keep the LED and remap bits from the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q   <= 1'b0;
            remap_q <= 1'b0;
        end else if (ctrl_we) begin
            led_q   <= led_bit;
            remap_q <= remap_bit;
        end
    end

    // Purpose: turn a reset-bit write into a single-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) reset_pulse <= 1'b0;
        else        reset_pulse <= ctrl_we & reset_bit;
    end

endmodule

// File: rtl/cm_ctrl_regs.sv
// Module: core module control register file (top). It decodes word-indexed
// register accesses, holds the plain words and builds the combinational read
// word. Assumes ADDR_W >= 9 so that the presence window fits.
module cm_ctrl_regs
    import cm_regs_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int MEM_MB  = 128,
    parameter int REF_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              remap_o,
    output logic              led_o,
    output logic              reset_req_o
);

    localparam int DATA_W = 32;
    localparam int NFLAG  = 2;
    localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);
    localparam logic [7:0]        DENSITY   = presence_density(MEM_MB);

    logic [ADDR_W-1:0] word_sel;
    logic              in_presence;
    logic [15:0]       lock_val;
    logic              lock_open;
    logic [31:0]       osc_val;
    logic [31:0]       aux_val;
    logic [31:0]       ref_count;
    logic [31:0]       sdram_q;
    logic [31:0]       init_q;
    logic [31:0]       flag_val [NFLAG];
    logic [NFLAG-1:0]  flag_set_we;
    logic [NFLAG-1:0]  flag_clr_we;
    logic              led_q;
    logic              remap_q;

    assign word_sel    = bus_addr >> 2;
    assign in_presence = (int'(bus_addr) >= PRESENCE_LO) && (int'(bus_addr) < PRESENCE_HI);

    // Purpose: report whether a write hits register index i.
    function automatic logic wr_hit(input logic [ADDR_W-1:0] sel, input int i);
        return bus_we && (sel == ADDR_W'(i));
    endfunction

    cm_key_lock #(.KEY_W(16), .DATA_W(DATA_W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_we   (wr_hit(word_sel, IDX_LOCK)),
        .word_we   ({wr_hit(word_sel, IDX_AUX), wr_hit(word_sel, IDX_OSC)}),
        .wdata     (bus_wdata),
        .lock_q    (lock_val),
        .lock_open (lock_open),
        .osc_q     (osc_val),
        .aux_q     (aux_val)
    );

    assign flag_set_we[0] = wr_hit(word_sel, IDX_FLAG_SET);
    assign flag_clr_we[0] = wr_hit(word_sel, IDX_FLAG_CLR);
    assign flag_set_we[1] = wr_hit(word_sel, IDX_NVF_SET);
    assign flag_clr_we[1] = wr_hit(word_sel, IDX_NVF_CLR);

    for (genvar f = 0; f < NFLAG; f++) begin : g_flags
        cm_setclr_bank #(.W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (flag_set_we[f]),
            .clr_we  (flag_clr_we[f]),
            .wdata   (bus_wdata),
            .flags_q (flag_val[f])
        );
    end

    cm_ref_counter #(.DIV(REF_DIV), .CNT_W(DATA_W)) u_refcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_q (ref_count)
    );

    cm_ctrl_unit u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (wr_hit(word_sel, IDX_CTRL)),
        .led_bit     (bus_wdata[0]),
        .remap_bit   (bus_wdata[2]),
        .reset_bit   (bus_wdata[3]),
        .led_q       (led_q),
        .remap_q     (remap_q),
        .reset_pulse (reset_req_o)
    );

    assign led_o   = led_q;
    assign remap_o = remap_q;

    // Purpose: hold the freely writable SDRAM and init words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdram_q <= SDRAM_RST;
            init_q  <= INIT_RST;
        end else begin
            if (wr_hit(word_sel, IDX_SDRAM)) sdram_q <= bus_wdata;
            if (wr_hit(word_sel, IDX_INIT))  init_q  <= bus_wdata;
        end
    end

    // Purpose: select the read word for the addressed register or window.
    always_comb begin
        bus_rdata = '0;
        if (in_presence) begin
            bus_rdata = {24'd0, presence_byte(word_sel[4:0], DENSITY)};
        end else begin
            case (word_sel)
                ADDR_W'(IDX_IDENT):    bus_rdata = IDENT_WORD;
                ADDR_W'(IDX_OSC):      bus_rdata = osc_val;
                ADDR_W'(IDX_CTRL):     bus_rdata = {29'd0, remap_q, 1'b0, led_q};
                ADDR_W'(IDX_STAT):     bus_rdata = STAT_WORD;
                ADDR_W'(IDX_LOCK):     bus_rdata = {15'd0, lock_open, lock_val};
                ADDR_W'(IDX_AUX):      bus_rdata = aux_val;
                ADDR_W'(IDX_SDRAM):    bus_rdata = sdram_q;
                ADDR_W'(IDX_INIT):     bus_rdata = init_q;
                ADDR_W'(IDX_REFCNT):   bus_rdata = ref_count;
                ADDR_W'(IDX_FLAG_SET): bus_rdata = flag_val[0];
                ADDR_W'(IDX_NVF_SET):  bus_rdata = flag_val[1];
                default:               bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cm_ctrl_regs_chk.sv
// Module: assertion checker for the control register file, bound to the top.
// Assumes the default register indices of the package.
module cm_ctrl_regs_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              reset_req_o,
    input logic              remap_o,
    input logic              lock_open,
    input logic [31:0]       osc_val,
    input logic [31:0]       ref_count,
    input logic [31:0]       flags0
);

    logic [ADDR_W-3:0] idx;
    assign idx = bus_addr[ADDR_W-1:2];

    // R5: the request lasts one cycle only
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o);

    // R5: a request always follows a reset-bit write to the control register
    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(bus_we && idx == (ADDR_W-2)'(3) && bus_wdata[3]));

    // R3: a locked oscillator write is dropped
    assert_osc_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && idx == (ADDR_W-2)'(2) && !lock_open) |=> $stable(osc_val));

    // R4: remap follows control bit 2 of the last write
    assert_remap_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && idx == (ADDR_W-2)'(3)) |=> (remap_o == $past(bus_wdata[2])));

    // R8: the reference count only ever steps by one
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_count) |-> (ref_count == $past(ref_count) + 32'd1));

    // R6: a clear write leaves none of its bits set
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && idx == (ADDR_W-2)'(13)) |=> ((flags0 & $past(bus_wdata)) == 32'd0));

endmodule

bind cm_ctrl_regs cm_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .reset_req_o (reset_req_o),
    .remap_o     (remap_o),
    .lock_open   (lock_open),
    .osc_val     (osc_val),
    .ref_count   (ref_count),
    .flags0      (flag_val[0])
);

// File: tb/tb_cm_ctrl_regs.sv
`timescale 1ns/1ps
// Bench: scoreboard for the control register file. The read driver queues
// expected words and a monitor compares them against the read port.
module tb_cm_ctrl_regs;

    localparam int ADDR_W  = 9;
    localparam int MEM_MB  = 128;
    localparam int REF_DIV = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              remap_o;
    logic              led_o;
    logic              reset_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       exp;
        string             tag;
    } item_t;

    item_t exp_q [$];

    always #2 clk = ~clk;

    cm_ctrl_regs #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB), .REF_DIV(REF_DIV)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .remap_o     (remap_o),
        .led_o       (led_o),
        .reset_req_o (reset_req_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected word per queued read and compares it.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    // Counts request pulses as seen at clock edges.
    always @(posedge clk) if (rst_n && reset_req_o) pulses++;

    task automatic wr(input int byte_off, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = ADDR_W'(byte_off);
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int byte_off, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = ADDR_W'(byte_off);
        bus_we   = 1'b0;
        it.addr = ADDR_W'(byte_off);
        it.exp  = e;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        rd(0,    32'h411A3001, "R1 ident");
        rd(4,    32'h0,        "R1 proc");
        rd(16,   32'h00100000, "R1 stat");
        rd(8,    32'h01000048, "R3 osc reset");
        rd(28,   32'h0007FEFF, "R3 aux reset");
        rd(20,   32'h0,        "R2 lock reset");
        rd(12,   32'h0,        "R4 ctrl reset");
        rd(32,   32'h0001112E, "R7 sdram reset");
        rd(36,   32'h00000112, "R7 init reset");
        rd(48,   32'h0,        "R6 flags reset");
        rd(56,   32'h0,        "R6 nvflags reset");
        @(negedge clk); #1;
        chk(led_o === 1'b0 && remap_o === 1'b0 && reset_req_o === 1'b0,
            "R4 outputs reset", {29'd0, reset_req_o, remap_o, led_o}, 32'd0);

        // Lock and guarded oscillator words.
        wr(8, 32'h12345678);
        rd(8,  32'h01000048, "R3 locked osc write dropped");
        wr(20, 32'h1234A05F);
        rd(20, 32'h0001A05F, "R2 key held reads open");
        wr(8, 32'h12345678);
        rd(8,  32'h12345678, "R3 open osc write");
        wr(28, 32'h0000CAFE);
        rd(28, 32'h0000CAFE, "R3 open aux write");
        wr(20, 32'h00001111);
        rd(20, 32'h00001111, "R2 other key reads stored");
        wr(28, 32'h00000001);
        rd(28, 32'h0000CAFE, "R3 relocked aux write dropped");
        wr(8, 32'h0);
        rd(8,  32'h12345678, "R3 relocked osc write dropped");

        // Control bits and reset request.
        wr(12, 32'hFFFFFFF5);
        rd(12, 32'h00000005, "R4 only bits 0 and 2 stored");
        @(negedge clk); #1;
        chk(led_o === 1'b1 && remap_o === 1'b1, "R4 led and remap high",
            {30'd0, remap_o, led_o}, 32'd3);
        chk(pulses == 0, "R5 no pulse without bit 3", 32'(pulses), 32'd0);
        @(negedge clk);
        bus_addr = ADDR_W'(12); bus_we = 1'b1; bus_wdata = 32'h00000008;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        chk(reset_req_o === 1'b1, "R5 pulse after write", {31'd0, reset_req_o}, 32'd1);
        @(negedge clk); #1;
        chk(reset_req_o === 1'b0, "R5 pulse ends", {31'd0, reset_req_o}, 32'd0);
        chk(pulses == 1, "R5 single pulse", 32'(pulses), 32'd1);
        rd(12, 32'h0, "R4 reset bit reads zero");
        @(negedge clk); #1;
        chk(led_o === 1'b0 && remap_o === 1'b0, "R4 outputs cleared",
            {30'd0, remap_o, led_o}, 32'd0);

        // Flag words.
        wr(48, 32'h000000F0);
        wr(48, 32'h00000003);
        rd(48, 32'h000000F3, "R6 set ORs");
        wr(52, 32'h00000031);
        rd(48, 32'h000000C2, "R6 clear removes bits");
        rd(52, 32'h0,        "R6 clear address reads zero");
        wr(56, 32'h0000A5A5);
        wr(60, 32'h00000005);
        rd(56, 32'h0000A5A0, "R6 second word set and clear");
        rd(48, 32'h000000C2, "R6 first word untouched");

        // Plain words.
        wr(32, 32'h0000DEAD);
        rd(32, 32'h0000DEAD, "R7 sdram write");
        wr(36, 32'h00000055);
        rd(36, 32'h00000055, "R7 init write");

        // Reference counter cadence.
        @(negedge clk);
        bus_addr = ADDR_W'(40);
        #1 c0 = bus_rdata;
        repeat (3 * REF_DIV) @(negedge clk);
        #1 c1 = bus_rdata;
        chk(c1 - c0 == 32'd3, "R8 three ticks in 3*REF_DIV cycles", c1 - c0, 32'd3);
        chk(c0 != 32'd0, "R8 counting since reset", c0, 32'd1);

        // Presence window.
        rd('h100, 32'h00000080, "R9 byte 0");
        rd('h108, 32'h00000004, "R9 byte 2");
        rd('h17C, 32'h00000020, "R9 density byte");
        rd('h180, 32'h0,        "R9 upper half zero");
        rd('h1FC, 32'h0,        "R9 last word zero");
        wr('h100, 32'h0);
        rd('h100, 32'h00000080, "R9 write ignored");

        // Unmapped indices.
        wr(24, 32'hFFFFFFFF);
        rd(24, 32'h0, "R10 index 6 reads zero");
        wr(44, 32'hFFFFFFFF);
        rd(44, 32'h0, "R10 index 11 reads zero");
        rd(160, 32'h0, "R10 index 40 reads zero");
        rd(48, 32'h000000C2, "R10 flags unchanged");
        rd(32, 32'h0000DEAD, "R10 sdram unchanged");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule